// File: doc/BRIEF.md
# Display Power-On Reset Sequencer

This block brings an attached display controller out of power-up. After a start pulse it asks for the panel supply, optionally probes the controller's power-mode register to learn whether the panel is already lit, and otherwise runs a full bring-up: a low pulse on the panel reset line, a settling wait, a one-byte soft reset command and a final wait. The final wait is short when a panel reset line is fitted and long when it is not, because without a hardware pulse the controller's state is unknown.

The supply and the serial command link are outside the block. The supply is a level request answered by a one-cycle `supply_ok` or `supply_fail`. Commands go out on a request/response port: `cmd_valid` with a byte, a read flag and a slow-clock flag, answered by a one-cycle `cmd_done` (with `rsp_byte` on reads) or `cmd_err`. Every wait is a count of clock cycles set by a parameter, and one down-counter times all of them.

States: IDLE (waiting for start), SUPPLY (supply requested), PROBE (power-mode read), PULSE (panel reset low), SETTLE (reset released, settling), SOFT (soft reset command), HOLD (post-command wait). Transitions: IDLE→SUPPLY on start; SUPPLY→IDLE on supply failure; SUPPLY→PROBE on supply ready in conditional mode, else to the reset entry; PROBE→IDLE when the display reads as on, else to the reset entry (also on a read error); the reset entry is PULSE when a reset line is fitted, otherwise SOFT; PULSE→SETTLE and SETTLE→SOFT when the counter expires; SOFT→HOLD on command done, SOFT→IDLE on command error; HOLD→IDLE when the counter expires.

Top module: `dpor_seq`

## Requirements
- R1: During and right after reset: `busy`=0, `outcome`=00 (none), `supply_on`=0, `panel_rst_n`=1, `cmd_valid`=0, `cmd_byte`=00.
- R2: A start accepted in IDLE raises `supply_on` and `busy` on the next cycle; a `supply_fail` answer ends the run with `outcome`=11 (error), `supply_on` low and no command issued.
- R3: In conditional mode, after `supply_ok`, the block issues a read of byte 0x0A with `cmd_read`=1 and `cmd_slow`=1 (the slow read clock, at most 2 MHz and half the fastest bus clock).
- R4: If the read returns a byte that, with bits 0, 1 and 7 cleared, equals 0x1C, the run ends with `outcome`=10 (already on), no reset pulse, and `supply_on` still high.
- R5: Any other readback value, or `cmd_err` on the read, continues with the full reset sequence.
- R6: With `rst_line_fitted`=1 latched at start, `panel_rst_n` is low for exactly PULSE_CYC cycles, then high for SETTLE_CYC cycles before the soft reset command; with it 0, no pulse is made.
- R7: The soft reset command is byte 0x01 with `cmd_read`=0 and `cmd_slow`=0.
- R8: After the soft reset is acknowledged the block waits SHORT_CYC cycles when a reset line is fitted, LONG_CYC cycles otherwise, then ends with `outcome`=01 (reset done).
- R9: `cmd_err` on the soft reset ends the run with `outcome`=11 and `supply_on` dropped.
- R10: A start while `busy` is ignored; `outcome` holds its value until the next accepted start, which clears it to 00.
- R11: A command request holds `cmd_valid` and `cmd_byte` stable until `cmd_done` or `cmd_err`; `cmd_byte` is 00 when no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only in IDLE |
| conditional | input | 1 | Probe power mode before resetting (latched at start) |
| rst_line_fitted | input | 1 | A panel reset line is present (latched at start) |
| supply_on | output | 1 | Supply enable request |
| supply_ok | input | 1 | One-cycle supply ready answer |
| supply_fail | input | 1 | One-cycle supply failure answer |
| panel_rst_n | output | 1 | Active-low panel reset line |
| cmd_valid | output | 1 | Command request |
| cmd_byte | output | 8 | Command byte |
| cmd_read | output | 1 | Request is a one-byte register read |
| cmd_slow | output | 1 | Use the slow read clock |
| cmd_done | input | 1 | One-cycle command completion |
| cmd_err | input | 1 | One-cycle command failure |
| rsp_byte | input | 8 | Read data, valid with cmd_done |
| busy | output | 1 | Sequence in progress |
| outcome | output | 2 | 00 none, 01 reset done, 10 already on, 11 error |

## Verification
The bench aims at the masked power-mode compare: a readback of 0x9F must count as on because only the ignored bits differ from 0x1C, while 0x3C must not; a design that masked the wrong bits would skip the reset wrongly or always reset. It checks that a read error falls through to the full reset instead of stopping, that the final wait length follows the fitted reset line (a swapped choice shows as an early or late end of busy), and that the reset pulse width is exact to the cycle. It also drives a start in the middle of a run, which a design that re-armed would show as a restarted supply request, and failures on the supply and on the soft reset, where a design that kept the supply on would be caught.

// File: rtl/dpor_pkg.sv
package dpor_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SUPPLY = 3'd1,
        ST_PROBE  = 3'd2,
        ST_PULSE  = 3'd3,
        ST_SETTLE = 3'd4,
        ST_SOFT   = 3'd5,
        ST_HOLD   = 3'd6
    } seq_state_t;

    typedef enum logic [1:0] {
        OC_NONE    = 2'b00,
        OC_DONE    = 2'b01,
        OC_ALREADY = 2'b10,
        OC_ERROR   = 2'b11
    } outcome_t;

    localparam logic [7:0] OP_SOFT_RESET = 8'h01;
    localparam logic [7:0] OP_READ_POWER = 8'h0A;
    localparam logic [7:0] PWR_IGNORE    = 8'h83;
    localparam logic [7:0] PWR_AWAKE     = 8'h1C;

endpackage

// File: rtl/dpor_delay.sv
module dpor_delay #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dpor_pm_check.sv
module dpor_pm_check
    import dpor_pkg::*;
(
    input  logic [7:0] pm_byte,
    output logic       awake
);
    logic [7:0] kept;

    always_comb begin
        kept  = pm_byte & ~PWR_IGNORE;
        awake = (kept == PWR_AWAKE);
    end
endmodule

// File: rtl/dpor_fsm.sv
module dpor_fsm
    import dpor_pkg::*;
#(
    parameter int PULSE_CYC  = 2000,
    parameter int SETTLE_CYC = 12000000,
    parameter int SHORT_CYC  = 500000,
    parameter int LONG_CYC   = 12000000,
    parameter int CNT_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             conditional,
    input  logic             rst_line_fitted,
    input  logic             supply_ok,
    input  logic             supply_fail,
    input  logic             cmd_done,
    input  logic             cmd_err,
    input  logic             pm_awake,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             supply_on,
    output logic             panel_rst_n,
    output logic             cmd_valid,
    output logic [7:0]       cmd_byte,
    output logic             cmd_read,
    output logic             cmd_slow,
    output logic             busy,
    output logic [1:0]       outcome
);
    localparam logic [CNT_W-1:0] PULSE_LD  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LD  = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LD   = CNT_W'(LONG_CYC - 1);

    seq_state_t state_q, state_n;
    outcome_t   outc_q, outc_n;
    logic       sup_q, sup_n;
    logic       cond_q, cond_n;
    logic       fit_q, fit_n;
    logic       go_reset;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            outc_q  <= OC_NONE;
            sup_q   <= 1'b0;
            cond_q  <= 1'b0;
            fit_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            outc_q  <= outc_n;
            sup_q   <= sup_n;
            cond_q  <= cond_n;
            fit_q   <= fit_n;
        end
    end

    // transitions
    always_comb begin
        state_n  = state_q;
        outc_n   = outc_q;
        sup_n    = sup_q;
        cond_n   = cond_q;
        fit_n    = fit_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        go_reset = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_SUPPLY;
                    sup_n   = 1'b1;
                    outc_n  = OC_NONE;
                    cond_n  = conditional;
                    fit_n   = rst_line_fitted;
                end
            end
            ST_SUPPLY: begin
                if (supply_fail) begin
                    state_n = ST_IDLE;
                    sup_n   = 1'b0;
                    outc_n  = OC_ERROR;
                end else if (supply_ok) begin
                    if (cond_q) begin
                        state_n = ST_PROBE;
                    end else begin
                        go_reset = 1'b1;
                    end
                end
            end
            ST_PROBE: begin
                if (cmd_done) begin
                    if (pm_awake) begin
                        state_n = ST_IDLE;
                        outc_n  = OC_ALREADY;
                    end else begin
                        go_reset = 1'b1;
                    end
                end else if (cmd_err) begin
                    go_reset = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    state_n  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_n = ST_SOFT;
                end
            end
            ST_SOFT: begin
                if (cmd_err) begin
                    state_n = ST_IDLE;
                    sup_n   = 1'b0;
                    outc_n  = OC_ERROR;
                end else if (cmd_done) begin
                    state_n  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = fit_q ? SHORT_LD : LONG_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    state_n = ST_IDLE;
                    outc_n  = OC_DONE;
                end
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase

        if (go_reset) begin
            if (fit_q) begin
                state_n  = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = PULSE_LD;
            end else begin
                state_n = ST_SOFT;
            end
        end
    end

    // outputs
    always_comb begin
        supply_on   = sup_q;
        outcome     = outc_q;
        busy        = (state_q != ST_IDLE);
        panel_rst_n = 1'b1;
        cmd_valid   = 1'b0;
        cmd_byte    = 8'h00;
        cmd_read    = 1'b0;
        cmd_slow    = 1'b0;
        unique case (state_q)
            ST_PROBE: begin
                cmd_valid = 1'b1;
                cmd_byte  = OP_READ_POWER;
                cmd_read  = 1'b1;
                cmd_slow  = 1'b1;
            end
            ST_PULSE: begin
                panel_rst_n = 1'b0;
            end
            ST_SOFT: begin
                cmd_valid = 1'b1;
                cmd_byte  = OP_SOFT_RESET;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/dpor_seq.sv
module dpor_seq #(
    parameter int PULSE_CYC  = 2000,
    parameter int SETTLE_CYC = 12000000,
    parameter int SHORT_CYC  = 500000,
    parameter int LONG_CYC   = 12000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       conditional,
    input  logic       rst_line_fitted,
    output logic       supply_on,
    input  logic       supply_ok,
    input  logic       supply_fail,
    output logic       panel_rst_n,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte,
    output logic       cmd_read,
    output logic       cmd_slow,
    input  logic       cmd_done,
    input  logic       cmd_err,
    input  logic [7:0] rsp_byte,
    output logic       busy,
    output logic [1:0] outcome
);
    localparam int MAX_AB  = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int MAX_CD  = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             pm_awake;

    dpor_delay #(.CNT_W(CNT_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dpor_pm_check u_pm (
        .pm_byte (rsp_byte),
        .awake   (pm_awake)
    );

    dpor_fsm #(
        .PULSE_CYC  (PULSE_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .SHORT_CYC  (SHORT_CYC),
        .LONG_CYC   (LONG_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .conditional     (conditional),
        .rst_line_fitted (rst_line_fitted),
        .supply_ok       (supply_ok),
        .supply_fail     (supply_fail),
        .cmd_done        (cmd_done),
        .cmd_err         (cmd_err),
        .pm_awake        (pm_awake),
        .tmr_expired     (tmr_expired),
        .tmr_load        (tmr_load),
        .tmr_val         (tmr_val),
        .supply_on       (supply_on),
        .panel_rst_n     (panel_rst_n),
        .cmd_valid       (cmd_valid),
        .cmd_byte        (cmd_byte),
        .cmd_read        (cmd_read),
        .cmd_slow        (cmd_slow),
        .busy            (busy),
        .outcome         (outcome)
    );
endmodule

// File: rtl/dpor_seq_chk.sv
module dpor_seq_chk #(
    parameter int PULSE_CYC = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_on,
    input logic       panel_rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       cmd_read,
    input logic       cmd_slow,
    input logic       cmd_done,
    input logic       cmd_err,
    input logic       busy,
    input logic [1:0] outcome
);
    int low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= 0;
        end else if (!panel_rst_n) begin
            low_q <= low_q + 1;
        end else begin
            low_q <= 0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && panel_rst_n));

    p_err_supply_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome == 2'b11) |-> !supply_on);

    p_read_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_read) |-> (cmd_slow && cmd_byte == 8'h0A));

    p_on_no_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome == 2'b10) |-> (panel_rst_n && supply_on));

    p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_rst_n) |-> (low_q == PULSE_CYC));

    p_soft_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_read) |-> (!cmd_slow && cmd_byte == 8'h01));

    p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (outcome == 2'b00));

    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done && !cmd_err) |=> (cmd_valid && $stable(cmd_byte)));
endmodule

bind dpor_seq dpor_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_on   (supply_on),
    .panel_rst_n (panel_rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_byte    (cmd_byte),
    .cmd_read    (cmd_read),
    .cmd_slow    (cmd_slow),
    .cmd_done    (cmd_done),
    .cmd_err     (cmd_err),
    .busy        (busy),
    .outcome     (outcome)
);

// File: tb/dpor_seq_tb.sv
module dpor_seq_tb;
    localparam int P_PULSE  = 3;
    localparam int P_SETTLE = 7;
    localparam int P_SHORT  = 4;
    localparam int P_LONG   = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       conditional = 1'b0;
    logic       rst_line_fitted = 1'b0;
    logic       supply_on;
    logic       supply_ok = 1'b0;
    logic       supply_fail = 1'b0;
    logic       panel_rst_n;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic       cmd_read;
    logic       cmd_slow;
    logic       cmd_done = 1'b0;
    logic       cmd_err = 1'b0;
    logic [7:0] rsp_byte = 8'h00;
    logic       busy;
    logic [1:0] outcome;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // responder configuration
    bit       cfg_sup_fail = 1'b0;
    bit       cfg_rd_err = 1'b0;
    bit [7:0] cfg_rd_data = 8'h00;
    bit       cfg_wr_err = 1'b0;

    always #5 clk = ~clk;

    dpor_seq #(
        .PULSE_CYC  (P_PULSE),
        .SETTLE_CYC (P_SETTLE),
        .SHORT_CYC  (P_SHORT),
        .LONG_CYC   (P_LONG)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .conditional (conditional),
        .rst_line_fitted (rst_line_fitted), .supply_on (supply_on),
        .supply_ok (supply_ok), .supply_fail (supply_fail),
        .panel_rst_n (panel_rst_n), .cmd_valid (cmd_valid), .cmd_byte (cmd_byte),
        .cmd_read (cmd_read), .cmd_slow (cmd_slow), .cmd_done (cmd_done),
        .cmd_err (cmd_err), .rsp_byte (rsp_byte), .busy (busy), .outcome (outcome)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference: phase codes and remaining-cycle count
    int       m_phase = 0;
    int       m_left = 0;
    bit       m_sup = 1'b0;
    bit [1:0] m_out = 2'b00;
    bit       m_cond = 1'b0;
    bit       m_fit = 1'b0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_phase <= 0; m_left <= 0; m_sup <= 1'b0; m_out <= 2'b00;
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_phase <= 1; m_sup <= 1'b1; m_out <= 2'b00;
                    m_cond <= conditional; m_fit <= rst_line_fitted;
                end
                1: if (supply_fail) begin
                    m_phase <= 0; m_sup <= 1'b0; m_out <= 2'b11;
                end else if (supply_ok) begin
                    if (m_cond) m_phase <= 2;
                    else if (m_fit) begin m_phase <= 3; m_left <= P_PULSE; end
                    else m_phase <= 5;
                end
                2: if (cmd_done && ((rsp_byte & 8'h7C) == 8'h1C)) begin
                    m_phase <= 0; m_out <= 2'b10;
                end else if (cmd_done || cmd_err) begin
                    if (m_fit) begin m_phase <= 3; m_left <= P_PULSE; end
                    else m_phase <= 5;
                end
                3: if (m_left == 1) begin m_phase <= 4; m_left <= P_SETTLE; end
                   else m_left <= m_left - 1;
                4: if (m_left == 1) m_phase <= 5;
                   else m_left <= m_left - 1;
                5: if (cmd_err) begin
                    m_phase <= 0; m_sup <= 1'b0; m_out <= 2'b11;
                end else if (cmd_done) begin
                    m_phase <= 6; m_left <= m_fit ? P_SHORT : P_LONG;
                end
                6: if (m_left == 1) begin m_phase <= 0; m_out <= 2'b01; end
                   else m_left <= m_left - 1;
                default: m_phase <= 0;
            endcase
        end
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R2 supply_on", {7'd0, supply_on}, {7'd0, m_sup});
            check("R6 panel_rst_n", {7'd0, panel_rst_n}, {7'd0, m_phase != 3});
            check("R11 cmd_valid", {7'd0, cmd_valid}, {7'd0, (m_phase == 2) || (m_phase == 5)});
            check("R7 cmd_byte", cmd_byte, (m_phase == 2) ? 8'h0A : (m_phase == 5) ? 8'h01 : 8'h00);
            check("R3 cmd_read", {7'd0, cmd_read}, {7'd0, m_phase == 2});
            check("R3 cmd_slow", {7'd0, cmd_slow}, {7'd0, m_phase == 2});
            check("R10 busy", {7'd0, busy}, {7'd0, m_phase != 0});
            check("R8 outcome", {6'd0, outcome}, {6'd0, m_out});
        end
    end

    // supply responder: answers two cycles after a run begins
    int  s_cnt = -1;
    bit  busy_prev = 1'b0;
    always @(negedge clk) begin
        supply_ok   <= 1'b0;
        supply_fail <= 1'b0;
        if (busy && !busy_prev) s_cnt = 2;
        else if (s_cnt > 0) s_cnt = s_cnt - 1;
        else if (s_cnt == 0) begin
            if (supply_on) begin
                if (cfg_sup_fail) supply_fail <= 1'b1;
                else supply_ok <= 1'b1;
            end
            s_cnt = -1;
        end
        busy_prev = busy;
    end

    // command responder: answers a request after two waiting cycles
    int  c_cnt = -1;
    bit  c_pulsed = 1'b0;
    always @(negedge clk) begin
        cmd_done <= 1'b0;
        cmd_err  <= 1'b0;
        if (c_pulsed) begin
            c_pulsed = 1'b0;
            c_cnt = -1;
        end else if (cmd_valid) begin
            if (c_cnt < 0) c_cnt = 2;
            else if (c_cnt > 0) c_cnt = c_cnt - 1;
            else begin
                if (cmd_read) begin
                    if (cfg_rd_err) cmd_err <= 1'b1;
                    else begin cmd_done <= 1'b1; rsp_byte <= cfg_rd_data; end
                end else begin
                    if (cfg_wr_err) cmd_err <= 1'b1;
                    else cmd_done <= 1'b1;
                end
                c_pulsed = 1'b1;
            end
        end else begin
            c_cnt = -1;
        end
    end

    task automatic run_seq(input bit cond, input bit fit, input bit sfail, input bit rerr,
                           input bit [7:0] rdata, input bit werr, input bit poke,
                           input bit [1:0] exp_out, input bit exp_sup, input string tag);
        int guard;
        cfg_sup_fail = sfail;
        cfg_rd_err   = rerr;
        cfg_rd_data  = rdata;
        cfg_wr_err   = werr;
        @(negedge clk);
        conditional     = cond;
        rst_line_fitted = fit;
        start           = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R10 outcome cleared by start"}, {6'd0, outcome}, 8'h00);
        check({tag, " R2 busy after start"}, {7'd0, busy}, 8'h01);
        if (poke) begin
            repeat (4) @(negedge clk);
            conditional = ~cond;
            rst_line_fitted = ~fit;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        check({tag, " outcome"}, {6'd0, outcome}, {6'd0, exp_out});
        check({tag, " supply_on"}, {7'd0, supply_on}, {7'd0, exp_sup});
        repeat (3) @(negedge clk);
        check({tag, " R10 outcome held"}, {6'd0, outcome}, {6'd0, exp_out});
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 busy in reset", {7'd0, busy}, 8'h00);
        check("R1 outcome in reset", {6'd0, outcome}, 8'h00);
        check("R1 supply_on in reset", {7'd0, supply_on}, 8'h00);
        check("R1 panel_rst_n in reset", {7'd0, panel_rst_n}, 8'h01);
        check("R1 cmd_valid in reset", {7'd0, cmd_valid}, 8'h00);
        check("R1 cmd_byte in reset", cmd_byte, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {6'd0, outcome, busy}, 8'h00);

        // R6 R8: unconditional, fitted line, all good -> reset done, short wait
        run_seq(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'b01, 1'b1, "R8 fitted");
        // R4: 0x9F masks to 0x1C -> already on
        run_seq(1'b1, 1'b1, 1'b0, 1'b0, 8'h9F, 1'b0, 1'b0, 2'b10, 1'b1, "R4 awake");
        // R5: 0x3C has bit 5 -> full reset, no line -> long wait
        run_seq(1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 2'b01, 1'b1, "R5 mismatch");
        // R5: read error -> full reset with pulse
        run_seq(1'b1, 1'b1, 1'b0, 1'b1, 8'h1C, 1'b0, 1'b0, 2'b01, 1'b1, "R5 read error");
        // R5: 0x14 missing bit 3 -> full reset
        run_seq(1'b1, 1'b1, 1'b0, 1'b0, 8'h14, 1'b0, 1'b0, 2'b01, 1'b1, "R5 partial");
        // R2: supply failure
        run_seq(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 2'b11, 1'b0, "R2 supply fail");
        // R9: soft reset failure
        run_seq(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'b11, 1'b0, "R9 soft fail");
        // R10: start while busy is ignored
        run_seq(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 2'b01, 1'b1, "R10 busy start");
        // R3 R7 R11: conditional run without reset line
        run_seq(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'b01, 1'b1, "R3 R7 R11 probe");

        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule